// File: doc/BRIEF.md
# Parallel-Port Block Transfer Engine

This block sits on the adapter side of a parallel-port link. It moves a run of bytes between the host and two local queues. The first is a read queue, which the drive side fills and the host drains. The second is a write queue, which the host fills and the drive side drains. A separate address decoder hands the engine a select byte together with a one-cycle valid pulse. The two top bits of that byte choose how the following burst is carried.

In nibble style, each read byte reaches the host as two 4-bit halves on the status lines. Writes in this style commit one data byte per control handshake. In wide style, reads go out as whole bytes on the data lines, advanced by toggling control values, and writes come in on an automatic write strobe. In the automatic-read style, each host read strobe delivers one byte. All outputs are registered. The engine reacts to the host control value on the clock edge where a new value is first sampled.

Top module: `pport_blk_xfer`

## Requirements
- R1: While reset is high, and after it, pd_out is 0x00, st_nib is 0x0, pd_oe is 0, rd_underflow is 0, wf_valid is 0, rf_full is 0, and the engine is idle.
- R2: On a sel_valid cycle, sel_byte bits 7:6 choose the style: 00 selects nibble, 11 selects wide, 10 selects automatic read, and 01 leaves the engine idle. Bits 5:0 have no effect. A select cycle performs no transfer action.
- R3: In nibble style, a change of ctrl to 0x06 puts the low half of the read-queue head on st_nib. A change from 0x06 to 0x04 puts the high half on st_nib and consumes the byte.
- R4: In wide style, a change of ctrl to 0xA6, or to 0xA4 from any value other than 0xAC, puts the read-queue head on pd_out and consumes it.
- R5: A change of ctrl from 0xAC to 0xA4 is an end-of-burst marker. It consumes nothing and leaves the current style active, so later read or write strobes are still served.
- R6: In automatic-read style, each cycle with epp_rd high loads the read-queue head into pd_out on the next edge and consumes it.
- R7: A change of ctrl from 0x07 to 0x05 in nibble style pushes pd_in into the write queue, as does every epp_wr cycle in wide style. wf_data shows the oldest entry while wf_valid is high, and wf_pop removes that entry.
- R8: A change of ctrl to 0x04 returns the wide and automatic-read styles to idle. In nibble style, entering 0x04 from any value other than 0x06 also returns to idle. While idle, ctrl changes, epp_rd and epp_wr leave pd_out, st_nib and the queues unchanged.
- R9: Consuming from an empty read queue yields 0xFF (nibbles 0xF) and sets rd_underflow. rd_underflow then stays high until reset.
- R10: pd_oe is high one edge after a cycle in which ctrl bit 5 is 1, or in which epp_rd is served in automatic-read style. Otherwise pd_oe is low.
- R11: Each queue holds DEPTH bytes. A push while the queue holds DEPTH bytes is dropped, even if a pop happens in the same cycle. rf_full is high at DEPTH entries. A fill and a consume in the same cycle both take effect, and a consume from an empty queue does not see a byte filled in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_byte | input | 8 | Select byte from the address decoder |
| sel_valid | input | 1 | One-cycle pulse: sel_byte is valid |
| ctrl | input | 8 | Host control value, sampled every clock |
| pd_in | input | 8 | Data lines as driven by the host |
| epp_rd | input | 1 | Automatic read strobe, one cycle per byte |
| epp_wr | input | 1 | Automatic write strobe, one cycle per byte |
| pd_out | output | 8 | Byte the adapter drives on the data lines |
| pd_oe | output | 1 | Adapter drives the data lines |
| st_nib | output | 4 | Nibble on the upper status lines |
| fill_en | input | 1 | Drive side pushes fill_data into the read queue |
| fill_data | input | 8 | Byte for the read queue |
| rf_full | output | 1 | Read queue holds DEPTH bytes |
| wf_pop | input | 1 | Drive side removes the write-queue head |
| wf_valid | output | 1 | Write queue is not empty |
| wf_data | output | 8 | Oldest write-queue byte |
| rd_underflow | output | 1 | Sticky: a read hit an empty queue |

## Verification
On the read queue, a drive-side fill can land in the same cycle as a host consume. This is provoked in two ways: by raising fill_en together with epp_rd while the queue is empty, and again while it is full. In the empty case, the host must get 0xFF and the filled byte must come out on the next read. In the full case, the consumed byte must be correct and the fill must be lost. On the write side, host pushes and drive-side pops are issued while entries are pending. A behavioural queue model updated on every edge judges every output, and explicit checks at each milestone name the requirement involved.

// File: rtl/pxfer_pkg.sv
package pxfer_pkg;

  typedef enum logic [1:0] {
    XM_IDLE  = 2'd0,
    XM_NIB   = 2'd1,
    XM_EPPRD = 2'd2,
    XM_WIDE  = 2'd3
  } xmode_e;

  localparam logic [7:0] CT_REST = 8'h04;
  localparam logic [7:0] CT_NLO  = 8'h06;
  localparam logic [7:0] CT_WSTB = 8'h07;
  localparam logic [7:0] CT_WREL = 8'h05;
  localparam logic [7:0] CT_BHI  = 8'hA6;
  localparam logic [7:0] CT_BLO  = 8'hA4;
  localparam logic [7:0] CT_MARK = 8'hAC;

  typedef struct packed {
    logic nib_lo;     // entered the low-nibble phase
    logic nib_hi;     // low phase -> rest: high-nibble phase
    logic rest;       // entered the rest value
    logic wr_commit;  // write strobe released
    logic byte_step;  // wide read advance
    logic mark;       // end-of-burst marker
  } ctl_ev_t;

  function automatic xmode_e decode_sel(input logic [1:0] hi);
    case (hi)
      2'b00:   return XM_NIB;
      2'b10:   return XM_EPPRD;
      2'b11:   return XM_WIDE;
      default: return XM_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/pxfer_fifo.sv
module pxfer_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  // R11
  fifo_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));

  // R11
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> full);

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> empty);

endmodule

// File: rtl/pxfer_ctrl_watch.sv
module pxfer_ctrl_watch
  import pxfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] ctrl,
  output ctl_ev_t    ev
);
  logic [7:0] prev_q;
  logic       chg;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= CT_REST;
    else     prev_q <= ctrl;
  end

  assign chg = (ctrl != prev_q);

  always_comb begin
    ev.nib_lo    = chg && (ctrl == CT_NLO);
    ev.rest      = chg && (ctrl == CT_REST);
    ev.nib_hi    = chg && (ctrl == CT_REST) && (prev_q == CT_NLO);
    ev.wr_commit = chg && (ctrl == CT_WREL) && (prev_q == CT_WSTB);
    ev.byte_step = chg && ((ctrl == CT_BHI) ||
                           ((ctrl == CT_BLO) && (prev_q != CT_MARK)));
    ev.mark      = chg && (ctrl == CT_BLO) && (prev_q == CT_MARK);
  end

endmodule

// File: rtl/pport_blk_xfer.sv
module pport_blk_xfer
  import pxfer_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] sel_byte,
  input  logic       sel_valid,
  input  logic [7:0] ctrl,
  input  logic [7:0] pd_in,
  input  logic       epp_rd,
  input  logic       epp_wr,
  output logic [7:0] pd_out,
  output logic       pd_oe,
  output logic [3:0] st_nib,
  input  logic       fill_en,
  input  logic [7:0] fill_data,
  output logic       rf_full,
  input  logic       wf_pop,
  output logic       wf_valid,
  output logic [7:0] wf_data,
  output logic       rd_underflow
);
  localparam int DW = 8;

  xmode_e        mode_q;
  ctl_ev_t       ev;
  logic [DW-1:0] rf_head, rd_byte;
  logic          rf_empty, wf_empty, wf_full_unused;
  logic          rd_take, wr_put, nib_lo_ld, nib_hi_ld, byte_ld, go_idle;
  logic          active;
  logic          sel_unused_bits;

  assign sel_unused_bits = ^sel_byte[5:0];

  pxfer_ctrl_watch u_watch (
    .clk (clk),
    .rst (rst),
    .ctrl(ctrl),
    .ev  (ev)
  );

  pxfer_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rdq (
    .clk  (clk),
    .rst  (rst),
    .push (fill_en),
    .din  (fill_data),
    .pop  (rd_take),
    .head (rf_head),
    .empty(rf_empty),
    .full (rf_full)
  );

  pxfer_fifo #(.DW(DW), .DEPTH(DEPTH)) u_wrq (
    .clk  (clk),
    .rst  (rst),
    .push (wr_put),
    .din  (pd_in),
    .pop  (wf_pop),
    .head (wf_data),
    .empty(wf_empty),
    .full (wf_full_unused)
  );

  assign wf_valid = !wf_empty;
  assign rd_byte  = rf_empty ? {DW{1'b1}} : rf_head;
  assign active   = !sel_valid;

  always_comb begin
    rd_take   = 1'b0;
    wr_put    = 1'b0;
    nib_lo_ld = 1'b0;
    nib_hi_ld = 1'b0;
    byte_ld   = 1'b0;
    go_idle   = 1'b0;
    if (active) begin
      unique case (mode_q)
        XM_NIB: begin
          nib_lo_ld = ev.nib_lo;
          nib_hi_ld = ev.nib_hi;
          rd_take   = ev.nib_hi;
          wr_put    = ev.wr_commit;
          go_idle   = ev.rest && !ev.nib_hi;
        end
        XM_WIDE: begin
          byte_ld = ev.byte_step;
          rd_take = ev.byte_step;
          wr_put  = epp_wr;
          go_idle = ev.rest;
        end
        XM_EPPRD: begin
          byte_ld = epp_rd;
          rd_take = epp_rd;
          go_idle = ev.rest;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= XM_IDLE;
      pd_out       <= '0;
      st_nib       <= '0;
      pd_oe        <= 1'b0;
      rd_underflow <= 1'b0;
    end else begin
      if (sel_valid)    mode_q <= decode_sel(sel_byte[7:6]);
      else if (go_idle) mode_q <= XM_IDLE;
      if (byte_ld)   pd_out <= rd_byte;
      if (nib_lo_ld) st_nib <= rd_byte[3:0];
      if (nib_hi_ld) st_nib <= rd_byte[7:4];
      pd_oe <= ctrl[5] || (active && (mode_q == XM_EPPRD) && epp_rd);
      if (rd_take && rf_empty) rd_underflow <= 1'b1;
    end
  end

  // R9
  unf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rd_underflow |=> rd_underflow);

  // R8
  end_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_valid && ev.rest && (mode_q == XM_WIDE || mode_q == XM_EPPRD))
    |=> (mode_q == XM_IDLE));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_valid && mode_q == XM_IDLE) |=> ($stable(pd_out) && $stable(st_nib)));

  // R10
  oe_dir_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl[5] |=> pd_oe);

  // R5
  mark_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ev.mark && !sel_valid && mode_q != XM_IDLE) |=> (mode_q == $past(mode_q)));

  // R2
  sel_none_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && sel_byte[7:6] == 2'b01) |=> (mode_q == XM_IDLE));

endmodule

// File: tb/test_pport_blk_xfer.sv
module test_pport_blk_xfer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sel_byte = 8'h00;
  logic       sel_valid = 1'b0;
  logic [7:0] ctrl = 8'h04;
  logic [7:0] pd_in = 8'h00;
  logic       epp_rd = 1'b0, epp_wr = 1'b0;
  logic       fill_en = 1'b0;
  logic [7:0] fill_data = 8'h00;
  logic       wf_pop = 1'b0;
  logic [7:0] pd_out, wf_data;
  logic [3:0] st_nib;
  logic       pd_oe, rf_full, wf_valid, rd_underflow;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";

  pport_blk_xfer #(.DEPTH(DEPTH)) i_pport_blk_xfer (
    .clk(clk), .rst(rst), .sel_byte(sel_byte), .sel_valid(sel_valid),
    .ctrl(ctrl), .pd_in(pd_in), .epp_rd(epp_rd), .epp_wr(epp_wr),
    .pd_out(pd_out), .pd_oe(pd_oe), .st_nib(st_nib),
    .fill_en(fill_en), .fill_data(fill_data), .rf_full(rf_full),
    .wf_pop(wf_pop), .wf_valid(wf_valid), .wf_data(wf_data),
    .rd_underflow(rd_underflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: 0 idle, 1 nibble, 2 auto read, 3 wide
  int         m_mode = 0;
  logic [7:0] m_prev = 8'h04, m_pd = 8'h00;
  logic [3:0] m_nib = 4'h0;
  logic       m_oe = 1'b0, m_unf = 1'b0;
  logic [7:0] rq[$];
  logic [7:0] wq[$];

  always @(posedge clk) begin
    bit chg, take, put, fill_ok, drain, room, nxt_oe;
    logic [7:0] rdb;
    if (rst) begin
      m_mode = 0; m_prev = 8'h04; m_pd = 8'h00; m_nib = 4'h0;
      m_oe = 1'b0; m_unf = 1'b0; rq.delete(); wq.delete();
    end else begin
      chg     = (ctrl != m_prev);
      rdb     = (rq.size() > 0) ? rq[0] : 8'hFF;
      take    = 0; put = 0;
      fill_ok = fill_en && (rq.size() < DEPTH);
      drain   = wf_pop && (wq.size() > 0);
      room    = (wq.size() < DEPTH);
      nxt_oe  = ctrl[5];
      if (sel_valid) begin
        case (sel_byte[7:6])
          2'b00: m_mode = 1;
          2'b10: m_mode = 2;
          2'b11: m_mode = 3;
          default: m_mode = 0;
        endcase
      end else begin
        case (m_mode)
          1: begin
            if (chg && ctrl == 8'h06) m_nib = rdb[3:0];
            else if (chg && ctrl == 8'h04 && m_prev == 8'h06) begin
              m_nib = rdb[7:4]; take = 1;
            end else if (chg && ctrl == 8'h04) m_mode = 0;
            else if (chg && ctrl == 8'h05 && m_prev == 8'h07) put = 1;
          end
          3: begin
            if (chg && (ctrl == 8'hA6 || (ctrl == 8'hA4 && m_prev != 8'hAC))) begin
              m_pd = rdb; take = 1;
            end
            if (epp_wr) put = 1;
            if (chg && ctrl == 8'h04) m_mode = 0;
          end
          2: begin
            if (epp_rd) begin m_pd = rdb; take = 1; nxt_oe = 1; end
            if (chg && ctrl == 8'h04) m_mode = 0;
          end
          default: ;
        endcase
      end
      if (take) begin
        if (rq.size() > 0) void'(rq.pop_front());
        else m_unf = 1'b1;
      end
      if (fill_ok) rq.push_back(fill_data);
      if (drain) void'(wq.pop_front());
      if (put && room) wq.push_back(pd_in);
      m_oe   = nxt_oe;
      m_prev = ctrl;
    end
  end

  task automatic cmp(string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst && !done) begin
      cmp("pd_out", pd_out, m_pd);
      cmp("pd_oe", {7'd0, pd_oe}, {7'd0, m_oe});
      cmp("st_nib", {4'd0, st_nib}, {4'd0, m_nib});
      cmp("rd_underflow", {7'd0, rd_underflow}, {7'd0, m_unf});
      cmp("rf_full", {7'd0, rf_full}, {7'd0, rq.size() == DEPTH});
      cmp("wf_valid", {7'd0, wf_valid}, {7'd0, wq.size() > 0});
      if (wq.size() > 0) cmp("wf_data", wf_data, wq[0]);
    end
  end

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // inputs are changed at a falling edge; each task ends at a falling edge
  task automatic tick(); @(negedge clk); endtask
  task automatic set_ctrl(logic [7:0] v); ctrl = v; tick(); endtask
  task automatic select(logic [7:0] b);
    sel_byte = b; sel_valid = 1'b1; tick(); sel_valid = 1'b0;
  endtask
  task automatic fill(logic [7:0] b);
    fill_en = 1'b1; fill_data = b; tick(); fill_en = 1'b0;
  endtask
  task automatic rd_strobe();
    epp_rd = 1'b1; tick(); epp_rd = 1'b0;
  endtask
  task automatic wr_strobe(logic [7:0] b);
    pd_in = b; epp_wr = 1'b1; tick(); epp_wr = 1'b0;
  endtask
  task automatic drain();
    wf_pop = 1'b1; tick(); wf_pop = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    cur_req = "R1";
    chk("R1 pd_out", pd_out, 8'h00);
    chk("R1 pd_oe", {7'd0, pd_oe}, 8'h00);
    rst = 1'b0;
    tick();
    cmp_on = 1'b1;
    chk("R1 st_nib", {4'd0, st_nib}, 8'h00);
    chk("R1 wf_valid/underflow", {6'd0, wf_valid, rd_underflow}, 8'h00);

    // nibble reads and handshake write
    cur_req = "R3";
    fill(8'hA5); fill(8'h3C); fill(8'h12); fill(8'hF0);
    select(8'h08);
    set_ctrl(8'h06); chk("R3 low nibble", {4'd0, st_nib}, 8'h05);
    set_ctrl(8'h04); chk("R3 high nibble", {4'd0, st_nib}, 8'h0A);
    set_ctrl(8'h06); chk("R3 next low", {4'd0, st_nib}, 8'h0C);
    set_ctrl(8'h04); chk("R3 next high", {4'd0, st_nib}, 8'h03);
    cur_req = "R7";
    set_ctrl(8'h05); pd_in = 8'h9E;
    set_ctrl(8'h07); set_ctrl(8'h05);
    chk("R7 handshake write", wf_data, 8'h9E);
    cur_req = "R8";
    set_ctrl(8'h04);
    set_ctrl(8'h06); chk("R8 idle ignores ctrl", {4'd0, st_nib}, 8'h03);
    set_ctrl(8'h04);
    drain(); chk("R7 drained", {7'd0, wf_valid}, 8'h00);

    // wide reads, marker, auto writes
    cur_req = "R4";
    select(8'hC8);
    set_ctrl(8'hA6); chk("R4 first byte", pd_out, 8'h12);
    chk("R10 oe on bit5", {7'd0, pd_oe}, 8'h01);
    set_ctrl(8'hA4); chk("R4 second byte", pd_out, 8'hF0);
    cur_req = "R5";
    set_ctrl(8'hAC); set_ctrl(8'hA4);
    chk("R5 marker consumes nothing", {7'd0, rd_underflow}, 8'h00);
    cur_req = "R7";
    set_ctrl(8'h05);
    chk("R10 oe off", {7'd0, pd_oe}, 8'h00);
    wr_strobe(8'h11); wr_strobe(8'h22);
    set_ctrl(8'h04);
    chk("R7 auto write head", wf_data, 8'h11);
    drain(); chk("R7 second entry", wf_data, 8'h22);
    drain();

    // automatic reads, marker, underflow, concurrency
    cur_req = "R6";
    fill(8'h01); fill(8'h02); fill(8'h03);
    select(8'h88);
    rd_strobe(); chk("R6 auto read", pd_out, 8'h01);
    chk("R10 oe on read", {7'd0, pd_oe}, 8'h01);
    tick(); chk("R10 oe drops", {7'd0, pd_oe}, 8'h00);
    cur_req = "R5";
    set_ctrl(8'hAC); set_ctrl(8'hA4);
    rd_strobe(); chk("R5 read after marker", pd_out, 8'h02);
    rd_strobe(); chk("R5 last byte", pd_out, 8'h03);
    cur_req = "R9";
    rd_strobe(); chk("R9 empty gives FF", pd_out, 8'hFF);
    chk("R9 underflow set", {7'd0, rd_underflow}, 8'h01);
    cur_req = "R11";
    fill_en = 1'b1; fill_data = 8'h44; epp_rd = 1'b1; tick();
    fill_en = 1'b0; epp_rd = 1'b0;
    chk("R11 fill+read on empty", pd_out, 8'hFF);
    rd_strobe(); chk("R11 filled byte kept", pd_out, 8'h44);
    cur_req = "R8";
    set_ctrl(8'h04);
    rd_strobe(); chk("R8 idle ignores read", pd_out, 8'h44);
    cur_req = "R2";
    select(8'h48);
    fill(8'h5A);
    rd_strobe(); chk("R2 unused code stays idle", pd_out, 8'h44);
    set_ctrl(8'hA6); chk("R2 no wide read", pd_out, 8'h44);
    set_ctrl(8'h04);
    select(8'h80); rd_strobe();
    chk("R2 low bits ignored", pd_out, 8'h5A);
    chk("R9 still sticky", {7'd0, rd_underflow}, 8'h01);

    // full read queue
    cur_req = "R11";
    for (int k = 0; k < DEPTH + 2; k++) fill(8'h60 + 8'(k));
    chk("R11 full flag", {7'd0, rf_full}, 8'h01);
    fill_en = 1'b1; fill_data = 8'h7F; epp_rd = 1'b1; tick();
    fill_en = 1'b0; epp_rd = 1'b0;
    chk("R11 read while full", pd_out, 8'h60);
    for (int k = 1; k < DEPTH; k++) rd_strobe();
    chk("R11 last kept", pd_out, 8'h60 + 8'(DEPTH - 1));
    rd_strobe(); chk("R11 extras dropped", pd_out, 8'hFF);
    set_ctrl(8'h04);

    // full write queue with concurrent drain
    cur_req = "R7";
    select(8'hC0);
    for (int k = 0; k < DEPTH + 1; k++) wr_strobe(8'h70 + 8'(k));
    pd_in = 8'h7E; epp_wr = 1'b1; wf_pop = 1'b1; tick();
    epp_wr = 1'b0; wf_pop = 1'b0;
    chk("R11 push dropped when full", wf_data, 8'h71);
    wr_strobe(8'h7D);
    for (int k = 0; k < DEPTH - 1; k++) drain();
    chk("R7 order kept", wf_data, 8'h7D);
    drain();
    set_ctrl(8'h04);

    cur_req = "R1";
    rst = 1'b1; tick(); tick();
    rst = 1'b0; tick();
    chk("R1 reset clears underflow", {7'd0, rd_underflow}, 8'h00);
    chk("R1 reset clears pd_out", pd_out, 8'h00);

    repeat (4) tick();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule